// File: doc/BRIEF.md
# Compact Quotient-Encoded Set Logic

This block is a purely combinational update unit for a small set of fingerprints kept in one densely packed word. Each fingerprint has two parts: a bucket index and a short remainder. Instead of storing every fingerprint at full width, the word keeps a unary occupancy header and a body of remainders sorted by bucket. For `M` buckets, up to `F` entries and `L`-bit remainders, the word is `M+F+F*L` bits wide. The default parameters give exactly 512 bits.

A caller presents the current word, an operation, a bucket and a remainder. In the same cycle the unit returns the updated word and three flags. The caller decides whether to write the returned word back to its storage. Hashing, storage and handling of more than one word belong to the surrounding logic.

The operation decoder has four named modes: QUERY, INSERT, DELETE and IDLE. Each mode selects one result from a datapath that all four share. That datapath has three stages:
- a locator that scans the header for the bucket's run;
- a matcher that compares the remainders inside that run;
- a shifter that opens or closes one header bit and one body slot.

There are no clocked states and no transitions. Every mode completes within the evaluation of its inputs.

Top module: `qset_core`

## Requirements
- R1: The word layout is fixed. Header bits `[M+F-1:0]` are read upward from bit 0. Each bucket, in increasing index order, contributes one 1-bit per stored entry followed by a terminating 0-bit. Header bits above the last terminator are 0. Body slot `s` occupies bits `[M+F+s*L +: L]`. Remainders are placed in bucket order, and unused slots at the top are all zero.
- R2: The operation code is 2'b00 query, 2'b01 insert, 2'b10 delete and 2'b11 idle. Idle returns the input word unchanged with all flags low.
- R3: Query raises `hit_o` exactly when some remainder in the selected bucket's run equals `rem_i`. The returned word equals the input word.
- R4: An insert on a word holding fewer than `F` entries places `rem_i` in the bucket's first slot and moves every later slot up by one. It also lengthens the bucket's header run by one 1-bit, shifting the header bits above it up by one.
- R5: An insert on a word already holding `F` entries raises `full_o` and returns the input word unchanged.
- R6: A delete whose remainder is present removes the lowest-numbered matching slot of that bucket. Later slots move down, the top slot becomes zero, and the bucket's header run loses one 1-bit.
- R7: A delete whose remainder is absent from the bucket, including the case of an empty bucket, raises `miss_o` and returns the input word unchanged.
- R8: At most one flag is high at a time. `hit_o` is only raised by query, `full_o` only by insert, and `miss_o` only by delete.
- R9: All outputs are a combinational function of the current inputs, with no clock and no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | M+F+F*L | Current packed set word |
| op_i | input | 2 | Operation code (R2) |
| bucket_i | input | clog2(M) | Bucket index of the fingerprint |
| rem_i | input | L | Remainder of the fingerprint |
| word_o | output | M+F+F*L | Updated packed set word |
| hit_o | output | 1 | Query found the remainder |
| full_o | output | 1 | Insert refused, set already holds F entries |
| miss_o | output | 1 | Delete found no matching remainder |

## Verification
The bench runs a long walk of mixed operations on a four-bucket, four-entry, 3-bit configuration. Remainders are drawn from the full 3-bit range, so duplicates within a bucket are common. This separates "first match removed" from "any match removed". It also separates the new entry going to the front of its run from going to the back.

Inserts are weighted so the walk repeatedly reaches a full word and exercises refused inserts. At intervals, every bucket and remainder pair is queried. This distinguishes a search confined to the bucket's run from a search that leaks into neighbouring runs.

Directed cases cover the following:
- an empty word;
- a single-entry word whose exact bit pattern pins the layout;
- deletes on empty and on non-matching buckets;
- the idle code.

// File: rtl/qset_pkg.sv
package qset_pkg;

    typedef enum logic [1:0] {
        OP_QUERY  = 2'b00,
        OP_INSERT = 2'b01,
        OP_DELETE = 2'b10,
        OP_IDLE   = 2'b11
    } qop_e;

endpackage

// File: rtl/qset_locate.sv
// Scans the unary header once and reports where a bucket's run lies.
module qset_locate #(
    parameter int M  = 32,
    parameter int F  = 32,
    localparam int H  = M + F,
    localparam int BW = $clog2(M),
    localparam int PW = $clog2(H),
    localparam int SW = $clog2(F + 1)
) (
    input  logic [H-1:0]  hdr_i,
    input  logic [BW-1:0] bucket_i,
    output logic [PW-1:0] start_o,
    output logic [PW-1:0] end_o,
    output logic [SW-1:0] first_o,
    output logic [SW-1:0] len_o,
    output logic [SW-1:0] count_o
);

    int  zc, ones, st, en, fi, tot;
    logic sf, ef, tf;

    always_comb begin
        zc = 0; ones = 0; st = 0; en = 0; fi = 0; tot = 0;
        sf = 1'b0; ef = 1'b0; tf = 1'b0;
        for (int i = 0; i < H; i++) begin
            if (zc == int'(bucket_i) && !sf) begin
                st = i;
                fi = ones;
                sf = 1'b1;
            end
            if (hdr_i[i]) begin
                if (zc < M) ones = ones + 1;
            end else begin
                if (zc == int'(bucket_i) && !ef) begin
                    en = i;
                    ef = 1'b1;
                end
                if (zc < M) zc = zc + 1;
                if (zc == M && !tf) begin
                    tot = ones;
                    tf  = 1'b1;
                end
            end
        end
        if (!tf) tot = ones;
        if (!ef) en = st;
        start_o = PW'(st);
        end_o   = PW'(en);
        first_o = SW'(fi);
        len_o   = SW'(en - st);
        count_o = SW'(tot);
    end

endmodule

// File: rtl/qset_match.sv
// Compares every body slot inside the bucket's run against the remainder.
module qset_match #(
    parameter int F  = 32,
    parameter int L  = 14,
    localparam int SW = $clog2(F + 1)
) (
    input  logic [F*L-1:0] body_i,
    input  logic [L-1:0]   rem_i,
    input  logic [SW-1:0]  first_i,
    input  logic [SW-1:0]  len_i,
    output logic           found_o,
    output logic [SW-1:0]  idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int s = 0; s < F; s++) begin
            if (!found_o
                && s >= int'(first_i)
                && s < int'(first_i) + int'(len_i)
                && body_i[s*L +: L] == rem_i) begin
                found_o = 1'b1;
                idx_o   = SW'(s);
            end
        end
    end

    always_comb begin
        if (found_o) begin
            AST_MATCH_IN_RUN: assert (idx_o >= first_i && int'(idx_o) < int'(first_i) + int'(len_i)); // R3
        end
    end

endmodule

// File: rtl/qset_shift.sv
// Produces both the opened (insert) and the closed (delete) word variants.
module qset_shift #(
    parameter int M  = 32,
    parameter int F  = 32,
    parameter int L  = 14,
    localparam int H  = M + F,
    localparam int FL = F * L,
    localparam int PW = $clog2(H),
    localparam int SW = $clog2(F + 1)
) (
    input  logic [H-1:0]  hdr_i,
    input  logic [FL-1:0] body_i,
    input  logic [L-1:0]  rem_i,
    input  logic [PW-1:0] hpos_ins_i,
    input  logic [PW-1:0] hpos_del_i,
    input  logic [SW-1:0] slot_ins_i,
    input  logic [SW-1:0] slot_del_i,
    output logic [H-1:0]  ins_hdr_o,
    output logic [FL-1:0] ins_body_o,
    output logic [H-1:0]  del_hdr_o,
    output logic [FL-1:0] del_body_o
);

    logic [H-1:0]  h_up, h_dn;
    logic [FL-1:0] b_up, b_dn;

    assign h_up = {hdr_i[H-2:0], 1'b0};
    assign h_dn = {1'b0, hdr_i[H-1:1]};
    assign b_up = {body_i[FL-L-1:0], {L{1'b0}}};
    assign b_dn = {{L{1'b0}}, body_i[FL-1:L]};

    always_comb begin
        for (int i = 0; i < H; i++) begin
            if (i < int'(hpos_ins_i))       ins_hdr_o[i] = hdr_i[i];
            else if (i == int'(hpos_ins_i)) ins_hdr_o[i] = 1'b1;
            else                            ins_hdr_o[i] = h_up[i];
            del_hdr_o[i] = (i < int'(hpos_del_i)) ? hdr_i[i] : h_dn[i];
        end
    end

    always_comb begin
        for (int s = 0; s < F; s++) begin
            if (s < int'(slot_ins_i))       ins_body_o[s*L +: L] = body_i[s*L +: L];
            else if (s == int'(slot_ins_i)) ins_body_o[s*L +: L] = rem_i;
            else                            ins_body_o[s*L +: L] = b_up[s*L +: L];
            del_body_o[s*L +: L] = (s < int'(slot_del_i)) ? body_i[s*L +: L] : b_dn[s*L +: L];
        end
    end

endmodule

// File: rtl/qset_core.sv
// Top: decodes the operation and selects one result of the shared datapath.
module qset_core #(
    parameter int M  = 32,
    parameter int F  = 32,
    parameter int L  = 14,
    localparam int H  = M + F,
    localparam int FL = F * L,
    localparam int W  = H + FL,
    localparam int BW = $clog2(M),
    localparam int PW = $clog2(H),
    localparam int SW = $clog2(F + 1)
) (
    input  logic [W-1:0]  word_i,
    input  logic [1:0]    op_i,
    input  logic [BW-1:0] bucket_i,
    input  logic [L-1:0]  rem_i,
    output logic [W-1:0]  word_o,
    output logic          hit_o,
    output logic          full_o,
    output logic          miss_o
);

    import qset_pkg::*;

    qop_e          op;
    logic [H-1:0]  hdr, ins_hdr, del_hdr;
    logic [FL-1:0] body, ins_body, del_body;
    logic [PW-1:0] run_start, run_end;
    logic [SW-1:0] run_first, run_len, n_stored, match_idx;
    logic          match_found;

    assign op   = qop_e'(op_i);
    assign hdr  = word_i[H-1:0];
    assign body = word_i[W-1:H];

    qset_locate #(.M(M), .F(F)) u_locate (
        .hdr_i    (hdr),
        .bucket_i (bucket_i),
        .start_o  (run_start),
        .end_o    (run_end),
        .first_o  (run_first),
        .len_o    (run_len),
        .count_o  (n_stored)
    );

    qset_match #(.F(F), .L(L)) u_match (
        .body_i  (body),
        .rem_i   (rem_i),
        .first_i (run_first),
        .len_i   (run_len),
        .found_o (match_found),
        .idx_o   (match_idx)
    );

    qset_shift #(.M(M), .F(F), .L(L)) u_shift (
        .hdr_i      (hdr),
        .body_i     (body),
        .rem_i      (rem_i),
        .hpos_ins_i (run_end),
        .hpos_del_i (run_start),
        .slot_ins_i (run_first),
        .slot_del_i (match_idx),
        .ins_hdr_o  (ins_hdr),
        .ins_body_o (ins_body),
        .del_hdr_o  (del_hdr),
        .del_body_o (del_body)
    );

    always_comb begin
        word_o = word_i;
        hit_o  = 1'b0;
        full_o = 1'b0;
        miss_o = 1'b0;
        unique case (op)
            OP_QUERY: begin
                hit_o = match_found;
            end
            OP_INSERT: begin
                if (int'(n_stored) >= F) full_o = 1'b1;
                else                     word_o = {ins_body, ins_hdr};
            end
            OP_DELETE: begin
                if (!match_found) miss_o = 1'b1;
                else              word_o = {del_body, del_hdr};
            end
            OP_IDLE: begin
                word_o = word_i;
            end
        endcase
    end

    always_comb begin
        AST_ONE_FLAG: assert ($onehot0({hit_o, full_o, miss_o})); // R8
        AST_FULL_HOLDS: assert (!full_o || word_o == word_i); // R5
        AST_MISS_HOLDS: assert (!miss_o || word_o == word_i); // R7
        if (op == OP_INSERT && !full_o) begin
            AST_INS_GROWS: assert ($countones(word_o[H-1:0]) == $countones(word_i[H-1:0]) + 1); // R4
        end
        if (op == OP_DELETE && !miss_o) begin
            AST_DEL_SHRINKS: assert ($countones(word_o[H-1:0]) + 1 == $countones(word_i[H-1:0])); // R6
        end
        if (op == OP_QUERY || op == OP_IDLE) begin
            AST_READ_KEEPS: assert (word_o == word_i); // R3
        end
    end

endmodule

// File: tb/qset_core_test.sv
`timescale 1ns/1ps
module qset_core_test;

    localparam int M = 4;
    localparam int F = 4;
    localparam int L = 3;
    localparam int H = M + F;
    localparam int W = H + F * L;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] word_i, word_o;
    logic [1:0]   op_i;
    logic [1:0]   bucket_i;
    logic [L-1:0] rem_i;
    logic         hit_o, full_o, miss_o;

    int cnt [M];
    int items [M][F];
    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    qset_core #(.M(M), .F(F), .L(L)) uut (
        .word_i   (word_i),
        .op_i     (op_i),
        .bucket_i (bucket_i),
        .rem_i    (rem_i),
        .word_o   (word_o),
        .hit_o    (hit_o),
        .full_o   (full_o),
        .miss_o   (miss_o)
    );

    function automatic logic [W-1:0] pack_model();
        logic [W-1:0] w = '0;
        int pos = 0;
        int slot = 0;
        for (int b = 0; b < M; b++) begin
            for (int j = 0; j < cnt[b]; j++) begin
                w[pos] = 1'b1;
                pos++;
                w[H + slot*L +: L] = L'(items[b][j]);
                slot++;
            end
            pos++;
        end
        return w;
    endfunction

    function automatic int stored();
        int t = 0;
        for (int b = 0; b < M; b++) t += cnt[b];
        return t;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clear_model();
        for (int b = 0; b < M; b++) cnt[b] = 0;
    endtask

    // One operation against the model; expectations follow the requirements.
    task automatic step(int o, int b, int r);
        logic [W-1:0] w0, w1;
        logic eh, ef, em;
        int at;
        w0 = pack_model();
        eh = 0; ef = 0; em = 0;
        case (o)
            0: for (int j = 0; j < cnt[b]; j++) if (items[b][j] == r) eh = 1;
            1: begin
                if (stored() == F) ef = 1;
                else begin
                    for (int j = cnt[b]; j > 0; j--) items[b][j] = items[b][j-1];
                    items[b][0] = r;
                    cnt[b]++;
                end
            end
            2: begin
                at = -1;
                for (int j = cnt[b] - 1; j >= 0; j--) if (items[b][j] == r) at = j;
                if (at < 0) em = 1;
                else begin
                    for (int j = at; j < cnt[b] - 1; j++) items[b][j] = items[b][j+1];
                    cnt[b]--;
                end
            end
            default: ;
        endcase
        w1 = pack_model();
        @(negedge clk);
        word_i = w0; op_i = 2'(o); bucket_i = 2'(b); rem_i = L'(r);
        #1;
        case (o)
            0: check("R3 query word", 64'(word_o), 64'(w1));
            1: check(ef ? "R5 full insert word" : "R4 insert word", 64'(word_o), 64'(w1));
            2: check(em ? "R7 missed delete word" : "R6 delete word", 64'(word_o), 64'(w1));
            default: check("R2 idle word", 64'(word_o), 64'(w1));
        endcase
        check(o == 0 ? "R3 hit flag"  : "R8 hit flag",  64'(hit_o),  64'(eh));
        check(o == 1 ? "R5 full flag" : "R8 full flag", 64'(full_o), 64'(ef));
        check(o == 2 ? "R7 miss flag" : "R8 miss flag", 64'(miss_o), 64'(em));
    endtask

    initial begin
        word_i = '0; op_i = 2'b11; bucket_i = '0; rem_i = '0;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Empty word: query every pair, then deletes on empty buckets.
        for (int b = 0; b < M; b++)
            for (int r = 0; r < (1 << L); r++) step(0, b, r);
        step(2, 3, 5);

        // R1: a single entry in bucket 1 with remainder 5 has an exact pattern.
        step(1, 1, 5);
        check("R1 packed layout", 64'(word_o), 64'(20'h00502));
        // R9: output follows a new input without any clock edge.
        word_i = '0; op_i = 2'b01; bucket_i = 2'd0; rem_i = 3'd7;
        #0.5;
        check("R9 combinational response", 64'(word_o), 64'(20'h00701));
        step(3, 1, 5);
        step(2, 1, 4);

        // Fill one bucket to capacity, then refused insert and idle.
        for (int k = 0; k < 3; k++) step(1, 1, k);
        step(1, 0, 6);
        step(1, 3, 6);
        step(3, 2, 2);
        for (int k = 0; k < 5; k++) step(2, 1, 5 - k);

        // Long mixed walk with periodic exhaustive query sweeps.
        clear_model();
        for (int n = 0; n < 4000; n++) begin
            int sel = $urandom % 10;
            int o = (sel < 4) ? 1 : (sel < 7) ? 2 : (sel < 9) ? 0 : 3;
            step(o, $urandom % M, $urandom % (1 << L));
            if (n % 200 == 199)
                for (int b = 0; b < M; b++)
                    for (int r = 0; r < (1 << L); r++) step(0, b, r);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule